// File: doc/BRIEF.md
# Accumulator store rounding unit

This block turns a 48-bit signed fractional accumulator into a 32-bit register value at the moment the accumulator is stored. Three mode bits choose the conversion: an integer/fractional select, a narrow/wide select (the signed/unsigned bit), and a round/truncate select. In integer mode the low word is passed through unchanged. In fractional mode the retained field is taken below eight sign-extension guard bits. A wide store keeps 32 bits and discards 8. A narrow store keeps 16 bits, discards 24, and is sign-extended to 32 bits.

Rounding uses round-to-nearest with ties to even. A result that cannot be represented saturates to the most positive or most negative code and raises an overflow flag. This covers guard bits that do not extend the sign, and a rounding increment that carries past the positive maximum. A store strobe starts the conversion. The result, the valid flag and the overflow flag are registered and appear one cycle later.

Top module: `acc_store_round`

## Requirements
- R1: `res_vld` is 1 in exactly the cycle after a cycle with `store_en` = 1, and 0 otherwise. `res` and `ovf` change only in that cycle.
- R2: While `rst` is high and after it, until the first store, `res_vld` = 0, `ovf` = 0 and `res` = 0.
- R3: With `mode_frac` = 0 (integer), `res` equals accumulator bits [31:0] and `ovf` = 0, whatever `mode_narrow` and `mode_rnd` are.
- R4: With `mode_frac` = 1, `mode_narrow` = 0 and `mode_rnd` = 0, `res` is accumulator bits [39:8] with the low 8 bits dropped and no rounding.
- R5: With `mode_frac` = 1, `mode_narrow` = 0 and `mode_rnd` = 1, `res` is bits [39:8] rounded by the low 8 bits. Below 0x80 the value truncates, and above 0x80 it increments.
- R6: With `mode_frac` = 1 and `mode_narrow` = 1, `res` is bits [39:24] rounded by the low 24 bits (0x800000 is the half point) and sign-extended to 32 bits. `mode_rnd` has no effect in this mode.
- R7: When the discarded bits equal exactly one half, the retained field is incremented only if its lsb is 1, so the result lsb is always 0.
- R8: In a wide fractional store, a value that is out of the 32-bit signed range after rounding gives `res` = 0x7FFFFFFF or 0x80000000, following the accumulator sign, with `ovf` = 1. Out of range means bits [47:39] are not all equal, or an increment passed 0x7FFFFFFF.
- R9: In a narrow store, a value that is out of the 16-bit signed range after rounding gives `res` = 0x00007FFF or 0xFFFF8000 with `ovf` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| store_en | input | 1 | store strobe |
| acc_in | input | 48 | accumulator value |
| mode_narrow | input | 1 | 1 = 16-bit fractional store |
| mode_frac | input | 1 | 1 = fractional, 0 = integer pass-through |
| mode_rnd | input | 1 | 1 = round wide stores, 0 = truncate |
| res | output | 32 | registered store result |
| res_vld | output | 1 | result valid |
| ovf | output | 1 | saturation occurred |

## Verification
The bench targets exact ties with an even and with an odd retained lsb in both store widths. A design that rounds ties away from zero would return odd results there. Accumulators that sit just past the guard range, or at the positive maximum with a round-up tail, expose missing saturation, which would show up as wrapped results with the wrong sign. Narrow stores with the round bit cleared catch a design that lets `mode_rnd` suppress 16-bit rounding. Negative narrow results catch zero-extension in place of sign-extension.

// File: rtl/acc_store_round_pkg.sv
package acc_store_round_pkg;
  typedef enum logic [1:0] {
    KIND_INT  = 2'd0,
    KIND_WIDE = 2'd1,
    KIND_NARW = 2'd2
  } store_kind_t;

  function automatic store_kind_t pick_kind(input logic frac, input logic narrow);
    if (!frac)  return KIND_INT;
    if (narrow) return KIND_NARW;
    return KIND_WIDE;
  endfunction
endpackage

// File: rtl/acc_round_lane.sv
module acc_round_lane #(
  parameter int ACC_W = 48,
  parameter int DROP  = 8,
  parameter int RES_W = 32
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic             rnd_en_i,
  output logic [RES_W-1:0] val_o,
  output logic             ovf_o
);
  localparam int KEEP_W = ACC_W - DROP;
  localparam int HI_W   = KEEP_W - RES_W + 2;
  localparam logic [DROP-1:0] HALF = {1'b1, {(DROP-1){1'b0}}};

  logic [KEEP_W-1:0] keep;
  logic [DROP-1:0]   disc;
  logic              inc;
  logic [KEEP_W:0]   sum;
  logic [HI_W-1:0]   hi;
  logic              fits;

  always_comb begin
    keep  = acc_i[ACC_W-1:DROP];
    disc  = acc_i[DROP-1:0];
    inc   = rnd_en_i && ((disc > HALF) || ((disc == HALF) && keep[0]));
    sum   = {keep[KEEP_W-1], keep} + {{KEEP_W{1'b0}}, inc};
    hi    = sum[KEEP_W:RES_W-1];
    fits  = (&hi) || !(|hi);
    ovf_o = !fits;
    if (fits)
      val_o = sum[RES_W-1:0];
    else if (sum[KEEP_W])
      val_o = {1'b1, {(RES_W-1){1'b0}}};
    else
      val_o = {1'b0, {(RES_W-1){1'b1}}};
  end
endmodule

// File: rtl/acc_out_stage.sv
module acc_out_stage #(
  parameter int OUT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [OUT_W-1:0] val_i,
  input  logic             ovf_i,
  output logic [OUT_W-1:0] val_q,
  output logic             ovf_q,
  output logic             vld_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= '0;
      ovf_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= load_i;
      if (load_i) begin
        val_q <= val_i;
        ovf_q <= ovf_i;
      end
    end
  end
endmodule

// File: rtl/acc_store_round.sv
module acc_store_round
  import acc_store_round_pkg::*;
#(
  parameter int ACC_W    = 48,
  parameter int GUARD    = 8,
  parameter int OUT_W    = 32,
  parameter int NARROW_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             store_en,
  input  logic [ACC_W-1:0] acc_in,
  input  logic             mode_narrow,
  input  logic             mode_frac,
  input  logic             mode_rnd,
  output logic [OUT_W-1:0] res,
  output logic             res_vld,
  output logic             ovf
);
  localparam int NLANE = 2;

  logic [OUT_W-1:0] lane_val [NLANE];
  logic             lane_ovf [NLANE];
  logic [OUT_W-1:0] nxt_val;
  logic             nxt_ovf;
  store_kind_t      kind;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int RW = (g == 0) ? OUT_W : NARROW_W;
    localparam int DR = ACC_W - GUARD - RW;
    logic [RW-1:0] v;
    logic          o;
    acc_round_lane #(.ACC_W(ACC_W), .DROP(DR), .RES_W(RW)) u_lane (
      .acc_i   (acc_in),
      .rnd_en_i((g == 0) ? mode_rnd : 1'b1),
      .val_o   (v),
      .ovf_o   (o)
    );
    assign lane_val[g] = OUT_W'($signed(v));
    assign lane_ovf[g] = o;
  end

  always_comb begin
    kind = pick_kind(mode_frac, mode_narrow);
    unique case (kind)
      KIND_WIDE: begin nxt_val = lane_val[0]; nxt_ovf = lane_ovf[0]; end
      KIND_NARW: begin nxt_val = lane_val[1]; nxt_ovf = lane_ovf[1]; end
      default:   begin nxt_val = acc_in[OUT_W-1:0]; nxt_ovf = 1'b0; end
    endcase
  end

  acc_out_stage #(.OUT_W(OUT_W)) u_out (
    .clk   (clk),
    .rst   (rst),
    .load_i(store_en),
    .val_i (nxt_val),
    .ovf_i (nxt_ovf),
    .val_q (res),
    .ovf_q (ovf),
    .vld_q (res_vld)
  );

  AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    res_vld == $past(store_en)); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !res_vld |-> ($stable(res) && $stable(ovf))); // R1
  AST_INT_NO_OVF: assert property (@(posedge clk) disable iff (rst)
    (res_vld && !$past(mode_frac)) |-> !ovf); // R3
  AST_NARROW_SEXT: assert property (@(posedge clk) disable iff (rst)
    (res_vld && $past(mode_frac) && $past(mode_narrow))
      |-> ((&res[OUT_W-1:NARROW_W-1]) || !(|res[OUT_W-1:NARROW_W-1]))); // R6
  AST_SAT_CODE: assert property (@(posedge clk) disable iff (rst)
    ovf |-> (res == {1'b0, {(OUT_W-1){1'b1}}} || res == {1'b1, {(OUT_W-1){1'b0}}} ||
             res == OUT_W'({1'b0, {(NARROW_W-1){1'b1}}}) ||
             res == {{(OUT_W-NARROW_W+1){1'b1}}, {(NARROW_W-1){1'b0}}})); // R8
endmodule

// File: tb/test_acc_store_round.sv
module test_acc_store_round;
  logic        clk = 1'b0;
  logic        rst;
  logic        store_en;
  logic [47:0] acc_in;
  logic        mode_narrow, mode_frac, mode_rnd;
  logic [31:0] res;
  logic        res_vld, ovf;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  acc_store_round i_acc_store_round (
    .clk(clk), .rst(rst), .store_en(store_en), .acc_in(acc_in),
    .mode_narrow(mode_narrow), .mode_frac(mode_frac), .mode_rnd(mode_rnd),
    .res(res), .res_vld(res_vld), .ovf(ovf)
  );

  function automatic logic [32:0] model(input logic [47:0] a, input bit nar,
                                        input bit frac, input bit rnd);
    longint v, keep, rem, half, mx, mn;
    int drop;
    if (!frac) return {1'b0, a[31:0]};
    v    = longint'({{16{a[47]}}, a});
    drop = nar ? 24 : 8;
    keep = v >>> drop;
    rem  = v & ((64'sd1 << drop) - 1);
    half = 64'sd1 << (drop - 1);
    if ((nar || rnd) && (rem > half || (rem == half && keep[0]))) keep = keep + 1;
    mx = nar ? 64'sd32767 : 64'sd2147483647;
    mn = -mx - 1;
    if (keep > mx) return {1'b1, mx[31:0]};
    if (keep < mn) return {1'b1, mn[31:0]};
    return {1'b0, keep[31:0]};
  endfunction

  task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic store(input string req, input logic [47:0] a, input bit nar,
                       input bit frac, input bit rnd);
    @(negedge clk);
    acc_in = a; mode_narrow = nar; mode_frac = frac; mode_rnd = rnd; store_en = 1'b1;
    @(negedge clk);
    store_en = 1'b0;
    check({req, " R1 vld"}, {32'd0, res_vld}, 33'd1);
    check(req, {ovf, res}, model(a, nar, frac, rnd));
    acc_in = ~a;
    @(negedge clk);
    check({req, " R1 idle"}, {res_vld, ovf, res[30:0]}, {1'b0, model(a, nar, frac, rnd)[32], model(a, nar, frac, rnd)[30:0]});
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd4321);
    rst = 1'b1; store_en = 1'b0; acc_in = '0;
    mode_narrow = 0; mode_frac = 0; mode_rnd = 0;
    repeat (3) @(negedge clk);
    check("R2 reset", {ovf, res}, 33'd0);
    check("R2 vld", {32'd0, res_vld}, 33'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 after", {res_vld, ovf, res[30:0]}, 33'd0);
    store("R3 int", 48'hFFFF_8765_4321, 1, 0, 1);
    store("R4 trunc", 48'h00_1234_5678_FF, 0, 1, 0);
    store("R5 up", 48'h00_1234_5678_81, 0, 1, 1);
    store("R5 down", 48'h00_1234_5678_7F, 0, 1, 1);
    store("R7 tie even32", 48'h00_1234_5678_80, 0, 1, 1);
    store("R7 tie odd32", 48'h00_1234_5679_80, 0, 1, 1);
    store("R6 rnd ignored", 48'h00_1235_80_0001, 1, 1, 0);
    store("R7 tie even16", 48'h00_1234_80_0000, 1, 1, 1);
    store("R7 tie odd16", 48'h00_1235_80_0000, 1, 1, 0);
    store("R6 neg", 48'hFF_8001_00_0000, 1, 1, 1);
    store("R8 pos guard", 48'h00_8000_0000_00, 0, 1, 0);
    store("R8 neg guard", 48'hFF_7FFF_FFFF_FF, 0, 1, 1);
    store("R8 round carry", 48'h00_7FFF_FFFF_80, 0, 1, 1);
    store("R9 round carry", 48'h00_7FFF_C0_0000, 1, 1, 1);
    store("R9 neg", 48'hFE_0000_00_0000, 1, 1, 0);
    for (int i = 0; i < 400; i++) begin
      logic [47:0] a;
      a = {$urandom, $urandom};
      case ($urandom % 4)
        1: a = {{8{a[39]}}, a[39:0]};
        2: a = {{8{a[39]}}, a[39:8], 8'h80};
        3: a = {{8{a[39]}}, a[39:24], 24'h800000};
        default: ;
      endcase
      store("R5/R6/R8/R9 random", a, 1'($urandom), 1'($urandom % 4 != 0), 1'($urandom));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); total++; bad++; $display("FAIL watchdog"); end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule